// File: doc/BRIEF.md
# Serial Receiver with Line Status Flags

This block receives asynchronous serial characters on a single line. It runs from a clock at sixteen times the bit rate, passes the line through a two-flop synchronizer and checks that a start bit is genuine before it samples anything. Each later bit is taken at the middle of its bit cell. The character length, parity mode and stick-parity option are the same settings the transmitter uses. Each finished character is loaded, right-aligned, into a receive buffer.

Alongside the buffer the block keeps a seven-bit line status word. It holds a data-ready flag and four error flags: overrun, parity error, framing error and break. The two upper bits pass the transmitter's empty indications through from inputs. The host has two active-low read strobes, one for the buffer and one for the status word. Each strobe is delayed through two flops in the receiver clock domain, and its clearing action fires on the rising edge, when the read ends.

Top module: `serial_rx_status`

## Requirements
- R1: The line is synchronized through two flops. A falling edge counts as a start bit only if the synchronized line is still low 8 ticks later. A low pulse shorter than that leaves the data-ready flag clear and the buffer unchanged.
- R2: The length code `len_sel` selects 5, 6, 7 or 8 data bits for 00, 01, 10 and 11. Bits arrive LSB first, 16 ticks apart, and are stored right-aligned in `rx_data` with the unused upper bits at zero.
- R3: Data ready (status bit 0) is set when a character completes. It stays set until the rising edge of `buf_rd_n`, and it is clear within four clocks of that edge.
- R4: With `par_off` low, a parity bit follows the data. With `par_stick` low, `par_odd`=0 expects even parity and `par_odd`=1 expects odd parity. A mismatch sets parity error (status bit 2).
- R5: With `par_stick` high and parity enabled, the expected parity bit equals `par_odd`, whatever the data.
- R6: Framing error (status bit 3) is set when the first stop bit is sampled low.
- R7: Break (status bit 4) is set when the data bits, the parity bit (if enabled) and the stop bit are all sampled low. Framing error is set with it.
- R8: If a character completes while data ready is still set, overrun (status bit 1) is set and the new character replaces the buffer contents.
- R9: The rising edge of `stat_rd_n` clears status bits 4 to 1 and leaves data ready alone. A buffer read leaves the error flags alone.
- R10: Status bit 6 mirrors `tx_empty` and bit 5 mirrors `thr_empty`.
- R11: After reset, `rx_data` and status bits 4 to 0 are zero.
- R12: With `par_off` high, no parity bit is expected and parity error never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16x oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial receive line, idle high |
| len_sel | input | 2 | Data length code |
| par_off | input | 1 | 1 disables parity |
| par_odd | input | 1 | Parity select: 0 even, 1 odd |
| par_stick | input | 1 | Stick parity enable |
| tx_empty | input | 1 | Transmitter empty, shown in status bit 6 |
| thr_empty | input | 1 | Holding register empty, shown in status bit 5 |
| buf_rd_n | input | 1 | Buffer read strobe, active low |
| stat_rd_n | input | 1 | Status read strobe, active low |
| rx_data | output | 8 | Receive buffer |
| status | output | 7 | Line status word |

## Verification
A sampler that is out of step shows up at `rx_data` as bits shifted by one position, or as spurious framing errors on the very next character. A wrong parity sense shows as parity error on a well-formed character. A flag register that clears on the wrong strobe, or on a strobe's falling edge, shows within four clocks of that strobe. This happens while the host is still holding the strobe low, so the bench samples status during the low phase and again after the release.

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic [1:0] len_sel,
  input  logic       par_off,
  input  logic       par_odd,
  input  logic       par_stick,
  input  logic       tx_empty,
  input  logic       thr_empty,
  input  logic       buf_rd_n,
  input  logic       stat_rd_n,
  output logic [7:0] rx_data,
  output logic [6:0] status
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] TICK_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] TICK_MID  = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bit_i;
  logic [7:0]    sh;
  logic          par_q;
  logic          rx_m, rx_s, rx_d;
  logic          b1, b2, s1, s2;
  logic          dr, oe, pe, fe, bi;

  logic          buf_rise, stat_rise, frame_done, tick_end, last_bit;
  logic [7:0]    aligned;
  logic          exp_par, pe_set, fe_set, bi_set;

  assign buf_rise   = b1 & ~b2;
  assign stat_rise  = s1 & ~s2;
  assign tick_end   = cnt == TICK_LAST;
  assign last_bit   = bit_i == {1'b1, len_sel};
  assign frame_done = (st == S_STOP) && tick_end;
  assign aligned    = sh >> (2'd3 - len_sel);
  assign exp_par    = par_stick ? par_odd : ((^aligned) ^ par_odd);
  assign pe_set     = !par_off && (par_q != exp_par);
  assign fe_set     = !rx_s;
  assign bi_set     = (aligned == 8'h00) && (par_off || !par_q) && !rx_s;

  assign status = {tx_empty, thr_empty, bi, fe, pe, oe, dr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
      b1   <= 1'b1;
      b2   <= 1'b1;
      s1   <= 1'b1;
      s2   <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
      rx_d <= rx_s;
      b1   <= buf_rd_n;
      b2   <= b1;
      s1   <= stat_rd_n;
      s2   <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bit_i <= '0;
      sh    <= '0;
      par_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (rx_d && !rx_s) st <= S_START;
        end
        S_START: begin
          if (cnt == TICK_MID) begin
            cnt   <= '0;
            bit_i <= '0;
            st    <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (tick_end) begin
            sh  <= {rx_s, sh[7:1]};
            cnt <= '0;
            if (last_bit) st <= par_off ? S_STOP : S_PAR;
            else          bit_i <= bit_i + 1'b1;
          end
        end
        S_PAR: begin
          cnt <= cnt + 1'b1;
          if (tick_end) begin
            par_q <= rx_s;
            cnt   <= '0;
            st    <= S_STOP;
          end
        end
        S_STOP: begin
          cnt <= cnt + 1'b1;
          if (tick_end) begin
            cnt <= '0;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      dr      <= 1'b0;
      oe      <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
      bi      <= 1'b0;
    end else begin
      if (frame_done) rx_data <= aligned;

      if (frame_done)    dr <= 1'b1;
      else if (buf_rise) dr <= 1'b0;

      if (frame_done && dr) oe <= 1'b1;
      else if (stat_rise)   oe <= 1'b0;

      if (frame_done && pe_set) pe <= 1'b1;
      else if (stat_rise)       pe <= 1'b0;

      if (frame_done && fe_set) fe <= 1'b1;
      else if (stat_rise)       fe <= 1'b0;

      if (frame_done && bi_set) bi <= 1'b1;
      else if (stat_rise)       bi <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       buf_rise,
  input logic       stat_rise,
  input logic [7:0] rx_data,
  input logic [6:0] status
);
  AST_DR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && !buf_rise |=> status[0]); // R3
  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rise && !done |=> !status[0]); // R3
  AST_DR_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(done)); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rise && !done |=> status[4:1] == 4'b0000); // R9
  AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |-> status[3]); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done && status[0] |=> status[1]); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rx_data)); // R2
endmodule

bind serial_rx_status serial_rx_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (frame_done),
  .buf_rise  (buf_rise),
  .stat_rise (stat_rise),
  .rx_data   (rx_data),
  .status    (status)
);

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_off = 1'b1, par_odd = 1'b0, par_stick = 1'b0;
  logic       tx_empty = 1'b1, thr_empty = 1'b0;
  logic       buf_rd_n = 1'b1, stat_rd_n = 1'b1;
  logic [7:0] rx_data;
  logic [6:0] status;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  serial_rx_status #(.OVS(OVS)) u_serial_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .len_sel(len_sel),
    .par_off(par_off), .par_odd(par_odd), .par_stick(par_stick),
    .tx_empty(tx_empty), .thr_empty(thr_empty),
    .buf_rd_n(buf_rd_n), .stat_rd_n(stat_rd_n),
    .rx_data(rx_data), .status(status)
  );

  // {len[1:0], par_off, par_odd, par_stick, flip_parity, stop_bit, data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5},
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2B},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h55},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h3C},
    {2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3C},
    {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_in = b;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] len, input logic poff, input logic pbit,
                            input logic [7:0] d, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) drive_bit(d[i]);
    if (!poff) drive_bit(pbit);
    drive_bit(stopb);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic read_buf();
    buf_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    buf_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_stat();
    stat_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    stat_rd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic good_par(input logic [1:0] len, input logic odd, input logic stick,
                                    input logic [7:0] d);
    return stick ? odd : ((^(d & len_mask(len))) ^ odd);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R10 pass-through bits
    check("R11 status", {27'd0, status[4:0]}, 32'd0);
    check("R11 rx_data", {24'd0, rx_data}, 32'd0);
    check("R10 upper bits", {30'd0, status[6:5]}, 32'd2);
    tx_empty = 1'b0; thr_empty = 1'b1;
    @(negedge clk);
    check("R10 upper bits swapped", {30'd0, status[6:5]}, 32'd1);

    // Table of frames: R2 R4 R5 R6 R7 R12
    for (int i = 0; i < 8; i++) begin
      logic [14:0] v;
      logic [7:0]  m;
      logic        pb, e_pe, e_fe, e_bi;
      v = VEC[i];
      read_stat();
      read_buf();
      len_sel = v[14:13]; par_off = v[12]; par_odd = v[11]; par_stick = v[10];
      @(negedge clk);
      pb   = good_par(v[14:13], v[11], v[10], v[7:0]) ^ v[9];
      m    = v[7:0] & len_mask(v[14:13]);
      e_pe = !v[12] && v[9];
      e_fe = !v[8];
      e_bi = (m == 8'h00) && (v[12] || !pb) && !v[8];
      send_frame(v[14:13], v[12], pb, v[7:0], v[8]);
      check("R2 data", {24'd0, rx_data}, {24'd0, m});
      check("R4 R5 R6 R7 R12 flags", {27'd0, status[4:0]},
            {27'd0, e_bi, e_fe, e_pe, 1'b0, 1'b1});
    end

    // R9: status read clears errors but keeps data ready
    check("R9 before status read", {30'd0, status[4], status[0]}, 32'd3);
    read_stat();
    check("R9 errors cleared", {27'd0, status[4:0]}, 32'd1);
    read_buf();
    check("R3 cleared by buffer read", {31'd0, status[0]}, 32'd0);
    rx_in = 1'b1;
    repeat (40) @(negedge clk);

    // R1: short low glitch is rejected
    len_sel = 2'b11; par_off = 1'b1; par_stick = 1'b0;
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
    repeat (60) @(negedge clk);
    check("R1 glitch no data ready", {31'd0, status[0]}, 32'd0);
    check("R1 glitch buffer unchanged", {24'd0, rx_data}, 32'h00);

    // R3: data ready held until the end of the buffer read
    send_frame(2'b11, 1'b1, 1'b0, 8'h6E, 1'b1);
    repeat (100) @(negedge clk);
    check("R3 held", {31'd0, status[0]}, 32'd1);
    buf_rd_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 held while strobe low", {31'd0, status[0]}, 32'd1);
    buf_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R3 cleared on release", {31'd0, status[0]}, 32'd0);

    // R8: overrun, new character replaces buffer
    send_frame(2'b11, 1'b1, 1'b0, 8'h11, 1'b1);
    send_frame(2'b11, 1'b1, 1'b0, 8'hC7, 1'b1);
    check("R8 overrun flag", {27'd0, status[4:0]}, 32'h03);
    check("R8 buffer overwritten", {24'd0, rx_data}, 32'hC7);

    // R9: buffer read leaves error flags
    read_buf();
    check("R9 overrun kept after buffer read", {27'd0, status[4:0]}, 32'h02);
    read_stat();
    check("R9 overrun cleared by status read", {27'd0, status[4:0]}, 32'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule